// File: doc/BRIEF.md
# Write-Through Data Cache Front End with Posted Store Queue

This block sits between a processor load/store port and a slow word-wide memory. Loads are served from a direct-mapped array of one-word lines. A load that misses fetches its word from memory, installs it, and then completes as a hit. Every store is posted into a small first-in first-out queue toward memory. If the store address is already cached, the store also updates the cached copy. A store that misses goes around the array and leaves tags, valid bits and data untouched.

A drain engine sends the oldest queued store to memory through a single valid/ready request port. The processor waits on a store only when the queue is full. If an entry leaves the queue in the same cycle that a store arrives at a full queue, that store is taken with no wait. A load miss whose address still has a store waiting in the queue lets the queue drain until no such entry remains. Only then does the load read memory, so it always sees the newest value.

Top module: `wt_cache_front`

## Requirements
- R1: A load that hits is accepted in the cycle it is presented (`cpu_req_ready` high), and `cpu_rsp_valid` is high with the cached word one cycle after acceptance.
- R2: A load that misses issues exactly one memory read, installs the returned word as a valid line, and then completes. A repeated load of the same address issues no further memory read.
- R3: A store to a cached address updates the cached word, so a following load returns the new value with no memory read. The store is also written to memory.
- R4: A store that misses changes no line. A later load of that address issues a memory read, and a load of the line already held at that index still hits with its old tag and data.
- R5: With the default depth, the store queue holds 4 entries. A store is accepted at once while fewer than 4 are queued, and `cpu_req_ready` stays low for a store while 4 are queued and none leaves.
- R6: When the queue is full and the head entry's memory write completes in the same cycle a store is presented, that store is accepted in that cycle.
- R7: Queued stores reach memory one at a time, in the order the processor issued them, each with its own address and data.
- R8: No memory read is issued for a load while a queued store to the same address is still waiting. The load returns the value of the newest store to that address.
- R9: Once `mem_req_valid` is high without `mem_req_ready`, the request stays valid with the same address, direction and data until it is accepted.
- R10: After reset the queue is empty, every line is invalid, and `mem_req_valid` and `cpu_rsp_valid` are low. The first load after reset therefore reads memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req_valid | input | 1 | Processor request present; held until accepted |
| cpu_req_write | input | 1 | 1 = store, 0 = load |
| cpu_req_addr | input | AW | Word address |
| cpu_req_wdata | input | DW | Store data |
| cpu_req_ready | output | 1 | Request accepted this cycle when valid |
| cpu_rsp_valid | output | 1 | Load data valid |
| cpu_rsp_rdata | output | DW | Load data |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | AW | Memory word address |
| mem_req_wdata | output | DW | Memory write data |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_rdata | input | DW | Read data |

## Verification
On every cycle, the assertions check the following: queue overflow and underflow; stability of a stalled memory request; the absence of a memory read while a matching store is queued; immediate store acceptance below full; and the absence of any line write on a store miss. Only the bench's scenarios can show the data values, the per-address read counts that reveal hits and misses, and the issue order of stores arriving at memory. The same holds for the same-cycle full-queue handoff and for the effect of a store miss on the line at a colliding index. Random mixes of loads and stores, with stalls from memory, probe the interaction between reads and queued writes.

// File: rtl/wt_cache_pkg.sv
package wt_cache_pkg;
  typedef enum logic [1:0] {
    PORT_IDLE    = 2'd0,
    PORT_WRITE   = 2'd1,
    PORT_RD_REQ  = 2'd2,
    PORT_RD_WAIT = 2'd3
  } port_state_e;
endpackage

// File: rtl/wt_store_queue.sv
module wt_store_queue #(
  parameter int DEPTH = 4,
  parameter int AW    = 10,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [AW-1:0] push_addr,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic          full,
  output logic          empty,
  output logic [AW-1:0] head_addr,
  output logic [DW-1:0] head_data,
  input  logic [AW-1:0] probe_addr,
  output logic          probe_hit
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = PW + 1;

  logic [AW-1:0]    addr_q [DEPTH];
  logic [DW-1:0]    data_q [DEPTH];
  logic [DEPTH-1:0] occ_q, occ_d;
  logic [PW-1:0]    rd_q, rd_d, wr_q, wr_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [DEPTH-1:0] match;

  assign full      = (cnt_q == CW'(DEPTH));
  assign empty     = (cnt_q == '0);
  assign head_addr = addr_q[rd_q];
  assign head_data = data_q[rd_q];

  for (genvar i = 0; i < DEPTH; i++) begin : g_probe
    assign match[i] = occ_q[i] && (addr_q[i] == probe_addr);
  end
  assign probe_hit = |match;

  always_comb begin
    occ_d = occ_q;
    rd_d  = rd_q;
    wr_d  = wr_q;
    cnt_d = cnt_q;
    if (pop) begin
      occ_d[rd_q] = 1'b0;
      rd_d        = (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
    end
    if (push) begin
      occ_d[wr_q] = 1'b1;
      wr_d        = (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
    end
    case ({push, pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ_q <= '0;
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      occ_q <= occ_d;
      rd_q  <= rd_d;
      wr_q  <= wr_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      addr_q[wr_q] <= push_addr;
      data_q[wr_q] <= push_data;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full) |-> pop); // R5
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty); // R7
  AST_OCC_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(occ_q) == int'(cnt_q)); // R7
endmodule

// File: rtl/wt_line_array.sv
module wt_line_array #(
  parameter int LINES = 16,
  parameter int AW    = 10,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] lk_addr,
  output logic          lk_hit,
  output logic [DW-1:0] lk_data,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data
);
  localparam int IW = $clog2(LINES);
  localparam int TW = AW - IW;

  logic [LINES-1:0] vld_q, vld_d;
  logic [TW-1:0]    tag_q  [LINES];
  logic [DW-1:0]    word_q [LINES];

  logic [IW-1:0] lk_idx, wr_idx;
  logic [TW-1:0] lk_tag, wr_tag;

  assign lk_idx  = lk_addr[IW-1:0];
  assign lk_tag  = lk_addr[AW-1:IW];
  assign wr_idx  = wr_addr[IW-1:0];
  assign wr_tag  = wr_addr[AW-1:IW];
  assign lk_hit  = vld_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
  assign lk_data = word_q[lk_idx];

  always_comb begin
    vld_d = vld_q;
    if (wr_en) vld_d[wr_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx]  <= wr_tag;
      word_q[wr_idx] <= wr_data;
    end
  end
endmodule

// File: rtl/wt_cache_front.sv
module wt_cache_front
  import wt_cache_pkg::*;
#(
  parameter int AW       = 10,
  parameter int DW       = 32,
  parameter int LINES    = 16,
  parameter int WB_DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_req_valid,
  input  logic          cpu_req_write,
  input  logic [AW-1:0] cpu_req_addr,
  input  logic [DW-1:0] cpu_req_wdata,
  output logic          cpu_req_ready,
  output logic          cpu_rsp_valid,
  output logic [DW-1:0] cpu_rsp_rdata,
  output logic          mem_req_valid,
  output logic          mem_req_write,
  output logic [AW-1:0] mem_req_addr,
  output logic [DW-1:0] mem_req_wdata,
  input  logic          mem_req_ready,
  input  logic          mem_rsp_valid,
  input  logic [DW-1:0] mem_rsp_rdata
);
  port_state_e   port_q, port_d;
  logic [AW-1:0] fill_addr_q, fill_addr_d;
  logic          rsp_vld_q;
  logic [DW-1:0] rsp_data_q;

  logic          lk_hit;
  logic [DW-1:0] lk_data;
  logic          line_we;
  logic [AW-1:0] line_waddr;
  logic [DW-1:0] line_wdata;

  logic          wb_full, wb_empty, wb_probe_hit, wb_push, wb_pop;
  logic [AW-1:0] wb_head_addr;
  logic [DW-1:0] wb_head_data;

  logic st_ready, st_acc, rd_acc, rd_miss_go, fill_done;

  assign wb_pop     = (port_q == PORT_WRITE) && mem_req_ready;
  assign st_ready   = !wb_full || wb_pop;
  assign cpu_req_ready = cpu_req_write ? st_ready : lk_hit;
  assign st_acc     = cpu_req_valid && cpu_req_write && st_ready;
  assign rd_acc     = cpu_req_valid && !cpu_req_write && lk_hit;
  assign rd_miss_go = cpu_req_valid && !cpu_req_write && !lk_hit && !wb_probe_hit;
  assign fill_done  = (port_q == PORT_RD_WAIT) && mem_rsp_valid;
  assign wb_push    = st_acc;

  assign line_we    = fill_done || (st_acc && lk_hit);
  assign line_waddr = fill_done ? fill_addr_q : cpu_req_addr;
  assign line_wdata = fill_done ? mem_rsp_rdata : cpu_req_wdata;

  wt_line_array #(.LINES(LINES), .AW(AW), .DW(DW)) u_lines (
    .clk     (clk),
    .rst_n   (rst_n),
    .lk_addr (cpu_req_addr),
    .lk_hit  (lk_hit),
    .lk_data (lk_data),
    .wr_en   (line_we),
    .wr_addr (line_waddr),
    .wr_data (line_wdata)
  );

  wt_store_queue #(.DEPTH(WB_DEPTH), .AW(AW), .DW(DW)) u_queue (
    .clk        (clk),
    .rst_n      (rst_n),
    .push       (wb_push),
    .push_addr  (cpu_req_addr),
    .push_data  (cpu_req_wdata),
    .pop        (wb_pop),
    .full       (wb_full),
    .empty      (wb_empty),
    .head_addr  (wb_head_addr),
    .head_data  (wb_head_data),
    .probe_addr (cpu_req_addr),
    .probe_hit  (wb_probe_hit)
  );

  always_comb begin
    port_d      = port_q;
    fill_addr_d = fill_addr_q;
    case (port_q)
      PORT_IDLE: begin
        if (rd_miss_go) begin
          port_d      = PORT_RD_REQ;
          fill_addr_d = cpu_req_addr;
        end else if (!wb_empty) begin
          port_d = PORT_WRITE;
        end
      end
      PORT_WRITE:   if (mem_req_ready) port_d = PORT_IDLE;
      PORT_RD_REQ:  if (mem_req_ready) port_d = PORT_RD_WAIT;
      PORT_RD_WAIT: if (mem_rsp_valid) port_d = PORT_IDLE;
      default:      port_d = PORT_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      port_q    <= PORT_IDLE;
      rsp_vld_q <= 1'b0;
    end else begin
      port_q    <= port_d;
      rsp_vld_q <= rd_acc;
    end
  end

  always_ff @(posedge clk) begin
    fill_addr_q <= fill_addr_d;
    if (rd_acc) rsp_data_q <= lk_data;
  end

  assign mem_req_valid = (port_q == PORT_WRITE) || (port_q == PORT_RD_REQ);
  assign mem_req_write = (port_q == PORT_WRITE);
  assign mem_req_addr  = (port_q == PORT_WRITE) ? wb_head_addr : fill_addr_q;
  assign mem_req_wdata = wb_head_data;
  assign cpu_rsp_valid = rsp_vld_q;
  assign cpu_rsp_rdata = rsp_data_q;

  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_write) && $stable(mem_req_wdata))); // R9
  AST_RD_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_write && cpu_req_valid && cpu_req_addr == mem_req_addr)
      |-> !wb_probe_hit); // R8
  AST_STORE_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req_valid && cpu_req_write && !wb_full) |-> cpu_req_ready); // R5
  AST_MISS_NO_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req_valid && cpu_req_write && !lk_hit && !fill_done) |-> !line_we); // R4
  AST_FILL_THEN_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_done && cpu_req_valid && !cpu_req_write && cpu_req_addr == fill_addr_q)
      |=> (!cpu_req_valid || cpu_req_write || cpu_req_ready)); // R2
endmodule

// File: tb/tb_wt_cache_front.sv
module tb_wt_cache_front;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 10;
  localparam int DW = 32;
  localparam int WR_LAT = 3;
  localparam int RD_LAT = 2;
  localparam int QMAX = 4096;

  logic clk = 1'b0;
  logic rst_n;
  logic          cpu_req_valid, cpu_req_write, cpu_req_ready, cpu_rsp_valid;
  logic [AW-1:0] cpu_req_addr;
  logic [DW-1:0] cpu_req_wdata, cpu_rsp_rdata;
  logic          mem_req_valid, mem_req_write, mem_req_ready, mem_rsp_valid;
  logic [AW-1:0] mem_req_addr;
  logic [DW-1:0] mem_req_wdata, mem_rsp_rdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  wt_cache_front #(.AW(AW), .DW(DW), .LINES(16), .WB_DEPTH(4)) dut (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_write(cpu_req_write),
    .cpu_req_addr(cpu_req_addr), .cpu_req_wdata(cpu_req_wdata),
    .cpu_req_ready(cpu_req_ready), .cpu_rsp_valid(cpu_rsp_valid),
    .cpu_rsp_rdata(cpu_rsp_rdata),
    .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_req_ready(mem_req_ready), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_rdata(mem_rsp_rdata)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  logic [DW-1:0] memarr  [2**AW];
  logic [DW-1:0] ref_mem [2**AW];
  logic [AW-1:0] exp_addr [QMAX];
  logic [DW-1:0] exp_data [QMAX];
  int exp_head = 0, exp_tail = 0;
  int rd_count = 0;
  int wait_cnt = 0;
  bit mem_hold = 0;
  bit rand_hold = 0;
  bit rd_pend = 0;
  int rd_left = 0;
  logic [AW-1:0] rd_addr = '0;

  function automatic logic [DW-1:0] init_word(int a);
    return DW'(a) * 32'h9E37_79B1 + 32'h0000_0005;
  endfunction

  task automatic chk(bit ok, string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  assign mem_req_ready = !mem_hold && mem_req_valid && !rd_pend &&
                         (wait_cnt >= (mem_req_write ? WR_LAT : 1));
  assign mem_rsp_valid = rd_pend && (rd_left == 0);
  assign mem_rsp_rdata = memarr[rd_addr];

  always @(posedge clk) begin
    if (rst_n) begin
      if (mem_req_valid && mem_req_ready) begin
        wait_cnt <= 0;
        if (mem_req_write) begin
          memarr[mem_req_addr] <= mem_req_wdata;
          if (exp_head < exp_tail) begin
            chk(mem_req_addr == exp_addr[exp_head % QMAX] &&
                mem_req_wdata == exp_data[exp_head % QMAX], "R7 write order",
                {22'd0, mem_req_addr} ^ mem_req_wdata,
                {22'd0, exp_addr[exp_head % QMAX]} ^ exp_data[exp_head % QMAX]);
            exp_head <= exp_head + 1;
          end else chk(0, "R7 unexpected write", mem_req_wdata, 0);
        end else begin
          rd_count <= rd_count + 1;
          rd_pend  <= 1;
          rd_left  <= RD_LAT;
          rd_addr  <= mem_req_addr;
        end
      end else if (mem_req_valid) begin
        wait_cnt <= wait_cnt + 1;
      end
      if (rd_pend) begin
        if (rd_left > 0) rd_left <= rd_left - 1;
        else rd_pend <= 0;
      end
    end
  end

  always @(negedge clk) if (rand_hold) mem_hold = ($urandom % 3) == 0;

  task automatic cpu_op(input bit wr, input int a, input logic [DW-1:0] d,
                        output logic [DW-1:0] rdata);
    @(negedge clk);
    cpu_req_valid = 1; cpu_req_write = wr;
    cpu_req_addr = AW'(a); cpu_req_wdata = d;
    #1;
    while (!cpu_req_ready) begin
      @(negedge clk); #1;
    end
    if (wr) begin
      ref_mem[a] = d;
      exp_addr[exp_tail % QMAX] = AW'(a);
      exp_data[exp_tail % QMAX] = d;
      exp_tail++;
    end
    @(negedge clk);
    cpu_req_valid = 0;
    rdata = cpu_rsp_rdata;
    if (!wr) begin
      chk(cpu_rsp_valid == 1'b1, "R1 rsp valid", DW'(cpu_rsp_valid), 1);
      chk(rdata == ref_mem[a], "R8 load value", rdata, ref_mem[a]);
    end
  endtask

  task automatic wait_drain();
    int guard = 0;
    while (exp_head != exp_tail && guard < 5000) begin
      @(negedge clk); guard++;
    end
    chk(exp_head == exp_tail, "R7 queue drained", DW'(exp_tail - exp_head), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_checks++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] r;
    int rc;
    void'($urandom(32'd1234));
    for (int i = 0; i < 2**AW; i++) begin
      memarr[i] = init_word(i); ref_mem[i] = init_word(i);
    end
    cpu_req_valid = 0; cpu_req_write = 0; cpu_req_addr = '0; cpu_req_wdata = '0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(cpu_rsp_valid == 0, "R10 rsp idle", DW'(cpu_rsp_valid), 0);
    chk(mem_req_valid == 0, "R10 mem idle", DW'(mem_req_valid), 0);

    rc = rd_count; cpu_op(0, 5, 0, r);
    chk(rd_count == rc + 1, "R10 first load misses", DW'(rd_count - rc), 1);
    chk(r == init_word(5), "R2 fill data", r, init_word(5));
    rc = rd_count; cpu_op(0, 5, 0, r);
    chk(rd_count == rc, "R2 repeat load hits", DW'(rd_count - rc), 0);
    chk(r == init_word(5), "R1 hit data", r, init_word(5));

    cpu_op(1, 5, 32'hAAAA_0005, r);
    rc = rd_count; cpu_op(0, 5, 0, r);
    chk(rd_count == rc, "R3 store hit no read", DW'(rd_count - rc), 0);
    chk(r == 32'hAAAA_0005, "R3 store hit data", r, 32'hAAAA_0005);
    wait_drain();
    chk(memarr[5] == 32'hAAAA_0005, "R3 memory written", memarr[5], 32'hAAAA_0005);

    cpu_op(1, 37, 32'hBBBB_0025, r);
    rc = rd_count; cpu_op(0, 5, 0, r);
    chk(rd_count == rc, "R4 colliding line kept", DW'(rd_count - rc), 0);
    chk(r == 32'hAAAA_0005, "R4 colliding line data", r, 32'hAAAA_0005);
    wait_drain();
    rc = rd_count; cpu_op(0, 37, 0, r);
    chk(rd_count == rc + 1, "R4 store miss no alloc", DW'(rd_count - rc), 1);

    mem_hold = 1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      cpu_req_valid = 1; cpu_req_write = 1; cpu_req_addr = AW'(40 + i);
      cpu_req_wdata = 32'hC000_0000 + i; #1;
      chk(cpu_req_ready == 1, "R5 accept below full", DW'(cpu_req_ready), 1);
      ref_mem[40 + i] = 32'hC000_0000 + i;
      exp_addr[exp_tail % QMAX] = AW'(40 + i);
      exp_data[exp_tail % QMAX] = 32'hC000_0000 + i;
      exp_tail++;
    end
    @(negedge clk);
    cpu_req_addr = AW'(44); cpu_req_wdata = 32'hC000_0004; #1;
    chk(cpu_req_ready == 0, "R5 stall when full", DW'(cpu_req_ready), 0);
    @(negedge clk); #1;
    chk(cpu_req_ready == 0, "R5 stall held", DW'(cpu_req_ready), 0);
    @(negedge clk);
    mem_hold = 0; #1;
    chk(cpu_req_ready == 1, "R6 same-cycle handoff", DW'(cpu_req_ready), 1);
    ref_mem[44] = 32'hC000_0004;
    exp_addr[exp_tail % QMAX] = AW'(44);
    exp_data[exp_tail % QMAX] = 32'hC000_0004;
    exp_tail++;
    @(negedge clk);
    cpu_req_valid = 0;
    wait_drain();

    mem_hold = 1;
    cpu_op(1, 50, 32'hDDDD_0032, r);
    rc = rd_count;
    @(negedge clk);
    cpu_req_valid = 1; cpu_req_write = 0; cpu_req_addr = AW'(50);
    repeat (6) @(negedge clk);
    chk(rd_count == rc, "R8 read held behind store", DW'(rd_count - rc), 0);
    cpu_req_valid = 0;
    mem_hold = 0;
    cpu_op(0, 50, 0, r);
    chk(r == 32'hDDDD_0032, "R8 newest store seen", r, 32'hDDDD_0032);

    rand_hold = 1;
    for (int n = 0; n < 600; n++) begin
      int a = $urandom_range(0, 47);
      if (($urandom % 10) < 4) cpu_op(1, a, $urandom, r);
      else cpu_op(0, a, 0, r);
    end
    rand_hold = 0;
    mem_hold = 0;
    wait_drain();
    for (int i = 0; i < 48; i++)
      chk(memarr[i] == ref_mem[i], "R7 final memory", memarr[i], ref_mem[i]);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule